// File: doc/BRIEF.md
# Mailbox Task Launch Controller

This block is the memory-mapped front end of a processing engine, which may be a DSP core or a reconfigurable fabric tile. A host processor fills a bank of 32-bit mailbox registers with a payload length and task parameters. It then writes the start address of the payload. That one write runs the whole job. The controller reads the payload word by word from memory and hands each word to the engine's load port. It then pulses the engine's start input, waits for the engine to report completion, and raises an interrupt that the host acknowledges.

The controller never looks inside the payload. Program code and a fabric configuration bitstream are loaded and launched the same way. Memory reads use a request channel with a valid/ready handshake, and only one read is outstanding at a time. The response arrives in a later cycle than the one in which its request was accepted. The load port also uses a valid/ready handshake.

Register word indices on `host_addr`: 0 = status/control, 1 = payload length in words, 2 = code address, 4 to 7 = task parameters. Status read layout: bits [1:0] give the phase (0 idle, 1 fetching, 2 running, 3 done), bit 2 is the sticky error flag, bit 3 is the pending interrupt.

Top module: `mbx_launch_ctrl`

## Requirements
- R1: After reset the status word reads 0, and `irq`, `eng_start`, `mem_req_valid` and `load_valid` are all low.
- R2: The length register (index 1) and the parameter registers (indices 4 to 7) read back what was written. Each parameter register drives its 32-bit slice of `eng_param`, with parameter k at bits [32k+31:32k].
- R3: A write to index 2 while the phase is idle and the length is nonzero starts a fetch. The fetch issues exactly length read requests, to addresses A, A+4, A+8 and so on in order. A request holds its valid and address steady until it is accepted.
- R4: Each returned word is presented on `load_data`, unaltered and in fetch order. It is held steady with `load_valid` until `load_ready` accepts it.
- R5: `eng_start` is high for exactly one cycle, in the cycle after the last payload word is accepted, and the phase then reads 2 (running).
- R6: With a length of 0, a code-address write issues no memory read, and `eng_start` pulses in the cycle after the write.
- R7: `eng_done` while running moves the phase to 3 (done) and raises `irq` in the next cycle.
- R8: `irq` stays high until the host writes a 1 to status bit 3. That write returns the phase to 0, and a status write with bit 3 clear leaves both unchanged.
- R9: A code-address write while the phase is not idle starts no fetch and leaves the code-address readback unchanged. It sets status bit 2, which stays set until a 1 is written to status bit 2.
- R10: `eng_done` while the phase is idle has no effect on the status word or on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | AW | Register word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the register at host_addr (combinational) |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response word |
| load_valid | output | 1 | Payload word valid toward the engine |
| load_ready | input | 1 | Engine accepts the payload word |
| load_data | output | 32 | Payload word |
| eng_start | output | 1 | Single-cycle engine start pulse |
| eng_done | input | 1 | Engine reports that its kernel is complete |
| eng_param | output | 32*NUM_PARAM | Task parameters, packed |
| irq | output | 1 | Completion interrupt to the host |

## Verification
A phase register that slips or sticks shows up at once in the status readback and on the handshake outputs. A spurious fetch appears as an extra read request within one cycle. A lost completion leaves `irq` low in the cycle after `eng_done`. A bad fetch address or word counter corrupts the address sequence or the count of loaded words, and the first such request exposes it. An off-by-one in the start timing moves `eng_start` away from the cycle that follows the last load acceptance. A missed or doubled pulse changes the number of start pulses seen per launch.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } mbx_state_e;

    typedef enum logic [1:0] {
        FP_IDLE = 2'd0,
        FP_REQ  = 2'd1,
        FP_WAIT = 2'd2,
        FP_PUSH = 2'd3
    } fetch_phase_e;

    localparam int IDX_STATUS  = 0;
    localparam int IDX_LENGTH  = 1;
    localparam int IDX_CODE    = 2;
    localparam int IDX_PARAM0  = 4;
    localparam int STS_ERR_BIT = 2;
    localparam int STS_IRQ_BIT = 3;

endpackage

// File: rtl/mbx_regs.sv
module mbx_regs
    import mbx_pkg::*;
#(
    parameter int AW        = 3,
    parameter int NUM_PARAM = 4,
    parameter int LEN_W     = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_wr,
    input  logic [AW-1:0]             host_addr,
    input  logic [31:0]               host_wdata,
    input  mbx_state_e                state,
    output logic [31:0]               host_rdata,
    output logic [LEN_W-1:0]          length,
    output logic [31:0]               code_addr,
    output logic [32*NUM_PARAM-1:0]   eng_param,
    output logic                      launch,
    output logic                      clr_done
);

    typedef struct packed {
        logic [LEN_W-1:0]                len;
        logic [31:0]                     code;
        logic                            err;
        logic [NUM_PARAM-1:0][31:0]      par;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d   = regs_q;
        launch   = 1'b0;
        clr_done = 1'b0;
        if (host_wr) begin
            if (int'(host_addr) == IDX_STATUS) begin
                if (host_wdata[STS_ERR_BIT]) begin
                    regs_d.err = 1'b0;
                end
                clr_done = host_wdata[STS_IRQ_BIT];
            end
            if (int'(host_addr) == IDX_LENGTH) begin
                regs_d.len = host_wdata[LEN_W-1:0];
            end
            if (int'(host_addr) == IDX_CODE) begin
                if (state == ST_IDLE) begin
                    regs_d.code = host_wdata;
                    launch      = 1'b1;
                end else begin
                    regs_d.err  = 1'b1;
                end
            end
            for (int i = 0; i < NUM_PARAM; i++) begin
                if (int'(host_addr) == IDX_PARAM0 + i) begin
                    regs_d.par[i] = host_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (int'(host_addr) == IDX_STATUS) begin
            host_rdata = {28'd0, state == ST_DONE, regs_q.err, state};
        end
        if (int'(host_addr) == IDX_LENGTH) begin
            host_rdata = 32'(regs_q.len);
        end
        if (int'(host_addr) == IDX_CODE) begin
            host_rdata = regs_q.code;
        end
        for (int i = 0; i < NUM_PARAM; i++) begin
            if (int'(host_addr) == IDX_PARAM0 + i) begin
                host_rdata = regs_q.par[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_PARAM; g++) begin : g_param
        assign eng_param[32*g +: 32] = regs_q.par[g];
    end

    assign length    = regs_q.len;
    assign code_addr = regs_q.code;

endmodule

// File: rtl/mbx_fetch.sv
module mbx_fetch
    import mbx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [31:0]       base,
    input  logic [LEN_W-1:0]  len,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [31:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              load_valid,
    input  logic              load_ready,
    output logic [31:0]       load_data,
    output logic              last_accept
);

    localparam logic [LEN_W-1:0] ONE_WORD  = LEN_W'(1);
    localparam logic [31:0]      WORD_STEP = 32'd4;

    typedef struct packed {
        fetch_phase_e      phase;
        logic [31:0]       addr;
        logic [LEN_W-1:0]  left;
        logic [31:0]       data;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d         = f_q;
        last_accept = 1'b0;
        case (f_q.phase)
            FP_IDLE: begin
                if (go) begin
                    f_d.addr  = base;
                    f_d.left  = len;
                    f_d.phase = FP_REQ;
                end
            end
            FP_REQ: begin
                if (mem_req_ready) begin
                    f_d.phase = FP_WAIT;
                end
            end
            FP_WAIT: begin
                if (mem_rsp_valid) begin
                    f_d.data  = mem_rsp_data;
                    f_d.phase = FP_PUSH;
                end
            end
            FP_PUSH: begin
                if (load_ready) begin
                    f_d.left = f_q.left - ONE_WORD;
                    if (f_q.left == ONE_WORD) begin
                        last_accept = 1'b1;
                        f_d.phase   = FP_IDLE;
                    end else begin
                        f_d.addr  = f_q.addr + WORD_STEP;
                        f_d.phase = FP_REQ;
                    end
                end
            end
            default: f_d.phase = FP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign mem_req_valid = (f_q.phase == FP_REQ);
    assign mem_req_addr  = f_q.addr;
    assign load_valid    = (f_q.phase == FP_PUSH);
    assign load_data     = f_q.data;

endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic       zero_len,
    input  logic       fetch_last,
    input  logic       eng_done,
    input  logic       clr_done,
    output mbx_state_e state,
    output logic       eng_start,
    output logic       irq
);

    typedef struct packed {
        mbx_state_e st;
        logic       start;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (launch) begin
                    if (zero_len) begin
                        s_d.st    = ST_RUN;
                        s_d.start = 1'b1;
                    end else begin
                        s_d.st    = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (fetch_last) begin
                    s_d.st    = ST_RUN;
                    s_d.start = 1'b1;
                end
            end
            ST_RUN: begin
                if (eng_done) begin
                    s_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                if (clr_done) begin
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, start: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign state     = s_q.st;
    assign eng_start = s_q.start;
    assign irq       = (s_q.st == ST_DONE);

endmodule

// File: rtl/mbx_launch_ctrl.sv
module mbx_launch_ctrl
    import mbx_pkg::*;
#(
    parameter int AW        = 3,
    parameter int NUM_PARAM = 4,
    parameter int LEN_W     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic [AW-1:0]            host_addr,
    input  logic [31:0]              host_wdata,
    output logic [31:0]              host_rdata,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic [31:0]              mem_req_addr,
    input  logic                     mem_rsp_valid,
    input  logic [31:0]              mem_rsp_data,
    output logic                     load_valid,
    input  logic                     load_ready,
    output logic [31:0]              load_data,
    output logic                     eng_start,
    input  logic                     eng_done,
    output logic [32*NUM_PARAM-1:0]  eng_param,
    output logic                     irq
);

    mbx_state_e        state_w;
    logic [LEN_W-1:0]  length_w;
    logic [31:0]       code_w;
    logic              launch_w;
    logic              clr_done_w;
    logic              zero_len_w;
    logic              fetch_go_w;
    logic              fetch_last_w;

    assign zero_len_w = (length_w == '0);
    assign fetch_go_w = launch_w && !zero_len_w;

    mbx_regs #(
        .AW        (AW),
        .NUM_PARAM (NUM_PARAM),
        .LEN_W     (LEN_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .state      (state_w),
        .host_rdata (host_rdata),
        .length     (length_w),
        .code_addr  (code_w),
        .eng_param  (eng_param),
        .launch     (launch_w),
        .clr_done   (clr_done_w)
    );

    mbx_fetch #(
        .LEN_W (LEN_W)
    ) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (fetch_go_w),
        .base          (host_wdata),
        .len           (length_w),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .load_valid    (load_valid),
        .load_ready    (load_ready),
        .load_data     (load_data),
        .last_accept   (fetch_last_w)
    );

    mbx_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch_w),
        .zero_len   (zero_len_w),
        .fetch_last (fetch_last_w),
        .eng_done   (eng_done),
        .clr_done   (clr_done_w),
        .state      (state_w),
        .eng_start  (eng_start),
        .irq        (irq)
    );

    logic unused_code;
    assign unused_code = ^code_w;

endmodule

// File: rtl/mbx_launch_ctrl_chk.sv
module mbx_launch_ctrl_chk
    import mbx_pkg::*;
#(
    parameter int AW = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic [AW-1:0] host_addr,
    input logic        wr_irq_bit,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        load_valid,
    input logic        load_ready,
    input logic [31:0] load_data,
    input logic        eng_start,
    input logic        eng_done,
    input logic        irq,
    input mbx_state_e  state
);

    logic ack_wr;
    assign ack_wr = host_wr && (int'(host_addr) == IDX_STATUS) && wr_irq_bit;

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_req_in_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> state == ST_FETCH);

    assert_load_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid && !load_ready |=> load_valid && $stable(load_data));

    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    assert_start_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> state == ST_RUN);

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(eng_done));

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !ack_wr |=> irq);

    assert_no_refetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN || state == ST_DONE) |=> state != ST_FETCH);

endmodule

bind mbx_launch_ctrl mbx_launch_ctrl_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr       (host_wr),
    .host_addr     (host_addr),
    .wr_irq_bit    (host_wdata[3]),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .load_valid    (load_valid),
    .load_ready    (load_ready),
    .load_data     (load_data),
    .eng_start     (eng_start),
    .eng_done      (eng_done),
    .irq           (irq),
    .state         (state_w)
);

// File: tb/mbx_launch_ctrl_bench.sv
`timescale 1ns/1ps
module mbx_launch_ctrl_bench;

    localparam int AW = 3;
    localparam int NP = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0;
    logic [AW-1:0]     host_addr = '0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [31:0]       mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rsp_data = '0;
    logic              load_valid;
    logic              load_ready = 1'b0;
    logic [31:0]       load_data;
    logic              eng_start;
    logic              eng_done = 1'b0;
    logic [32*NP-1:0]  eng_param;
    logic              irq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int mode = 0;
    int nreq = 0, nload = 0, nstart = 0;
    int addr_err = 0, data_err = 0;
    int start_cyc = 0, last_acc_cyc = 0, wr_cyc = 0;
    logic [31:0] exp_base = '0;

    always #2.5 clk = ~clk;

    mbx_launch_ctrl #(.AW(AW), .NUM_PARAM(NP), .LEN_W(16)) u_mbx_launch_ctrl (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .load_valid(load_valid),
        .load_ready(load_ready), .load_data(load_data), .eng_start(eng_start),
        .eng_done(eng_done), .eng_param(eng_param), .irq(irq)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h0F0F0F0F;
    endfunction

    // memory model, ready patterns and event monitor
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_addr != exp_base + 32'(4 * nreq)) addr_err = addr_err + 1;
            nreq = nreq + 1;
        end
        if (load_valid && load_ready) begin
            if (load_data != word_of(exp_base + 32'(4 * nload))) data_err = data_err + 1;
            nload = nload + 1;
            last_acc_cyc = cyc;
        end
        if (eng_start) begin
            nstart = nstart + 1;
            start_cyc = cyc;
        end
        if (host_wr && int'(host_addr) == 2) wr_cyc = cyc;
        mem_rsp_valid <= mem_req_valid && mem_req_ready;
        mem_rsp_data  <= word_of(mem_req_addr);
        mem_req_ready <= (mode == 0) ? 1'b1 : (cyc % 3 == 0);
        load_ready    <= (mode == 0) ? 1'b1 : (cyc % 4 >= 2);
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [31:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_addr = AW'(a); host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input int a, output logic [31:0] v);
        @(negedge clk);
        host_addr = AW'(a);
        #1 v = host_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic wait_start();
        for (int i = 0; i < 3000 && nstart == 0; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        host_read(0, v);
        check("R1", "status after reset", v, 32'h0);
        check("R1", "irq after reset", 32'(irq), 32'h0);
        check("R1", "eng_start after reset", 32'(eng_start), 32'h0);
        check("R1", "mem_req_valid after reset", 32'(mem_req_valid), 32'h0);
        check("R1", "load_valid after reset", 32'(load_valid), 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        host_write(1, 32'd9);
        host_read(1, v);
        check("R2", "length readback", v, 32'd9);
        for (int k = 0; k < NP; k++) host_write(4 + k, 32'hC0DE_0000 + 32'(k * 17));
        for (int k = 0; k < NP; k++) begin
            host_read(4 + k, v);
            check("R2", "param readback", v, 32'hC0DE_0000 + 32'(k * 17));
            check("R2", "param output slice", eng_param[32*k +: 32], 32'hC0DE_0000 + 32'(k * 17));
        end
    endtask

    task automatic t_launch(input logic [31:0] base, input int len, input int m);
        logic [31:0] v;
        mode = m;
        host_write(1, 32'(len));
        nreq = 0; nload = 0; nstart = 0; addr_err = 0; data_err = 0;
        exp_base = base;
        host_write(2, base);
        wait_start();
        check("R3", "read request count", 32'(nreq), 32'(len));
        check("R3", "read address sequence errors", 32'(addr_err), 32'h0);
        check("R4", "loaded word count", 32'(nload), 32'(len));
        check("R4", "loaded word mismatches", 32'(data_err), 32'h0);
        check("R5", "start one cycle after last accept", 32'(start_cyc), 32'(last_acc_cyc + 1));
        repeat (3) @(negedge clk);
        check("R5", "start pulse count", 32'(nstart), 32'd1);
        host_read(0, v);
        check("R5", "phase running", 32'(v[1:0]), 32'd2);
        // busy code-address write is ignored and flagged
        host_write(2, base + 32'h100);
        host_read(0, v);
        check("R9", "error bit after busy write", 32'(v[2]), 32'd1);
        host_read(2, v);
        check("R9", "code address unchanged", v, base);
        repeat (4) @(negedge clk);
        check("R9", "no extra reads", 32'(nreq), 32'(len));
        pulse_done();
        check("R7", "irq after done", 32'(irq), 32'd1);
        host_read(0, v);
        check("R7", "phase done", 32'(v[1:0]), 32'd3);
        host_write(2, base + 32'h200);
        repeat (3) @(negedge clk);
        check("R9", "no fetch from done phase", 32'(nreq), 32'(len));
        host_write(0, 32'h0);
        check("R8", "irq held after write without bit 3", 32'(irq), 32'd1);
        host_write(0, 32'h8);
        check("R8", "irq cleared by acknowledge", 32'(irq), 32'd0);
        host_read(0, v);
        check("R8", "phase idle after acknowledge", 32'(v[1:0]), 32'd0);
        check("R9", "error bit sticky", 32'(v[2]), 32'd1);
        host_write(0, 32'h4);
        host_read(0, v);
        check("R9", "error bit cleared", 32'(v[2]), 32'd0);
        mode = 0;
    endtask

    task automatic t_zero();
        logic [31:0] v;
        host_write(1, 32'd0);
        nreq = 0; nload = 0; nstart = 0;
        host_write(2, 32'h0000_8000);
        wait_start();
        check("R6", "start one cycle after write", 32'(start_cyc), 32'(wr_cyc + 1));
        repeat (3) @(negedge clk);
        check("R6", "no memory read", 32'(nreq), 32'd0);
        check("R6", "single start", 32'(nstart), 32'd1);
        host_read(0, v);
        check("R6", "phase running", 32'(v[1:0]), 32'd2);
        pulse_done();
        host_write(0, 32'h8);
        host_read(0, v);
        check("R8", "idle after zero-length task", v, 32'h0);
    endtask

    task automatic t_done_idle();
        logic [31:0] v;
        pulse_done();
        repeat (2) @(negedge clk);
        check("R10", "irq stays low on idle done", 32'(irq), 32'd0);
        host_read(0, v);
        check("R10", "status unchanged on idle done", v, 32'h0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures = failures + 1;
        $display("FAIL watchdog: actual=expired expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_launch(32'h0000_1000, 4, 0);
        t_launch(32'h2000_0040, 7, 1);
        t_zero();
        t_done_idle();
        t_launch(32'h0000_0100, 1, 1);
        finish_run();
    end

endmodule